// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of a conditional branch by combining two component predictors. The first is a table of 2-bit saturating counters indexed by a register that holds the outcomes of the most recent resolved branches, so it captures correlation between different branches. The second is a two-level predictor. A table indexed by branch address holds each branch's own recent outcome history, and that history pattern selects a 3-bit saturating counter. A per-address 2-bit chooser counter decides which of the two component predictions becomes the final answer.

A fetch stage presents the low index bits of a branch address and reads back the final prediction together with both component predictions in the same cycle. The read is combinational from the stored state. When the branch resolves, the pipeline returns the address, the real outcome, and the two component predictions that were made for it. All tables and histories then train in the next clock edge. The block assumes that no other branch resolves between a prediction and its own resolve. The global history is the committed one: there is no speculative history and no recovery.

Top module: `tourney_pred`

## Requirements
- R1: After a synchronous active-low reset, all histories are zero. Every 2-bit counter holds 1, every 3-bit counter holds 3, and every chooser holds 1. Every request therefore reads pred_gbl=0, pred_lcl=0 and pred_taken=0.
- R2: pred_gbl is 1 when the 2-bit global counter selected by the global history register holds 2 or more. On each resolve, the history shifts left and the new outcome enters bit 0.
- R3: pred_lcl is 1 when the 3-bit counter selected by the local history holds 4 or more. The local history is read from the history table entry at req_idx[LHT_IDX_W-1:0]. On resolve, that entry shifts left with the outcome entering bit 0.
- R4: On a resolve, each component counter steps up on a taken outcome and down on a not-taken outcome. It stops at its maximum (3 or 7) and at 0.
- R5: Chooser values 0 and 1 select pred_gbl, and values 2 and 3 select pred_lcl, as pred_taken.
- R6: The chooser entry at upd_idx steps toward local (up) when the local prediction was right and the global one wrong. It steps toward global (down) in the reverse case. It saturates at 0 and 3.
- R7: When both component predictions were right, or both were wrong, the chooser entry does not change.
- R8: Both component counters and both histories train on every resolve, whichever component the chooser picked.
- R9: With upd_valid low, no state changes, whatever the other update inputs carry.
- R10: The chooser is indexed by the full req_idx/upd_idx, while the local history table uses only its low LHT_IDX_W bits. Indices equal in those low bits share a local history but keep separate choosers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_idx | input | CHS_IDX_W | Low address bits of the branch being predicted |
| pred_taken | output | 1 | Final direction chosen by the chooser |
| pred_gbl | output | 1 | Global component prediction |
| pred_lcl | output | 1 | Local component prediction |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_idx | input | CHS_IDX_W | Low address bits of the resolving branch |
| upd_taken | input | 1 | Actual outcome of the resolving branch |
| upd_gbl_pred | input | 1 | Global prediction that was made for it |
| upd_lcl_pred | input | 1 | Local prediction that was made for it |

## Verification
The in-line properties guard the following on every cycle:
- counter saturation and single steps in each table;
- that an entry without a write holds its value;
- that the global history takes in each outcome;
- that the final prediction matches the components whenever they agree.

Only the bench scenarios can show the effects that depend on table contents. These include the chooser migrating between components after one-sided wins, and the local table learning an alternating pattern. They also include the global table capturing cross-branch correlation and aliasing between indices that share low bits. The bench tracks these with an independent reference model and compares all three prediction outputs on every step.

// File: rtl/tp_pkg.sv
// Shared constants for the tournament predictor.
// Assumes: counter widths are fixed by the scheme; table depths come from top parameters.
package tp_pkg;
    localparam int GCTR_W   = 2;   // global component counter width
    localparam int LCTR_W   = 3;   // local component counter width
    localparam int CHS_W    = 2;   // chooser counter width
    localparam int GCTR_RST = 1;   // weakly not taken
    localparam int LCTR_RST = 3;   // weakly not taken
    localparam int CHS_RST  = 1;   // weakly prefer global

    typedef enum logic {
        PICK_GLOBAL = 1'b0,
        PICK_LOCAL  = 1'b1
    } pick_e;
endpackage

// File: rtl/tp_sat_table.sv
// Table of saturating up/down counters with one combinational read port
// (MSB only, i.e. the upper half of the range) and one write port.
// Assumes: at most one write per cycle; synchronous active-low reset loads RST_VAL.
module tp_sat_table #(
    parameter int IDX_W   = 8,
    parameter int CW      = 2,
    parameter int RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_hi,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int          DEPTH = 1 << IDX_W;
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [CW-1:0] CMIN = '0;
    localparam logic [CW-1:0] CONE = CW'(1);
    localparam logic [CW-1:0] CRST = CW'(RST_VAL);

    logic [CW-1:0] ctr_q [DEPTH];
    logic [CW-1:0] wr_old;

    // Upper half of the counter range reads as "high".
    assign rd_hi  = ctr_q[rd_idx][CW-1];
    assign wr_old = ctr_q[wr_idx];

    // Reset every counter, else step the written entry with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CRST;
        end else if (wr_en) begin
            if (wr_up && wr_old != CMAX)
                ctr_q[wr_idx] <= wr_old + CONE;
            else if (!wr_up && wr_old != CMIN)
                ctr_q[wr_idx] <= wr_old - CONE;
        end
    end

    // R4
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && wr_old == CMAX) |=> (ctr_q[$past(wr_idx)] == CMAX))
        else $error("counter left its maximum on an up step");

    // R4
    sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && wr_old == CMIN) |=> (ctr_q[$past(wr_idx)] == CMIN))
        else $error("counter left zero on a down step");

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && wr_old != CMAX) |=> (ctr_q[$past(wr_idx)] == $past(wr_old) + CONE))
        else $error("up step was not exactly one");

    // R7
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> (ctr_q[$past(wr_idx)] == $past(wr_old)))
        else $error("counter changed without a write");
endmodule

// File: rtl/tp_hist_unit.sv
// Global outcome shift register plus per-address local history table.
// Assumes: histories are committed at resolve only (no speculative copy);
// newest outcome enters bit 0.
module tp_hist_unit #(
    parameter int GH_W      = 8,
    parameter int LHT_IDX_W = 6,
    parameter int LH_W      = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LHT_IDX_W-1:0] rd_idx,
    output logic [LH_W-1:0]      lhist_rd,
    output logic [GH_W-1:0]      ghist,
    input  logic                 upd_valid,
    input  logic [LHT_IDX_W-1:0] wr_idx,
    input  logic                 upd_taken,
    output logic [LH_W-1:0]      lhist_wr
);
    localparam int LHT_DEPTH = 1 << LHT_IDX_W;

    logic [GH_W-1:0] ghist_q;
    logic [LH_W-1:0] lht_q [LHT_DEPTH];

    assign ghist    = ghist_q;
    assign lhist_rd = lht_q[rd_idx];
    assign lhist_wr = lht_q[wr_idx];

    // Shift the committed global history on each resolve.
    always_ff @(posedge clk) begin
        if (!rst_n)         ghist_q <= '0;
        else if (upd_valid) ghist_q <= {ghist_q[GH_W-2:0], upd_taken};
    end

    // Shift the resolving branch's own history entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LHT_DEPTH; i++) lht_q[i] <= '0;
        end else if (upd_valid) begin
            lht_q[wr_idx] <= {lhist_wr[LH_W-2:0], upd_taken};
        end
    end

    // R2
    ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist_q[0] == $past(upd_taken)
                       && ghist_q[GH_W-1:1] == $past(ghist_q[GH_W-2:0])))
        else $error("global history did not take in the outcome");

    // R9
    ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghist_q))
        else $error("global history moved without a resolve");

    // R3
    lhist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (lht_q[$past(wr_idx)][0] == $past(upd_taken)))
        else $error("local history did not take in the outcome");
endmodule

// File: rtl/tourney_pred.sv
// Tournament direction predictor: a global-history table of 2-bit counters,
// a two-level local predictor with 3-bit counters, and a per-index 2-bit chooser.
// Assumes: one branch in flight between predict and resolve; the caller returns
// the component predictions it was given; LHT_IDX_W <= CHS_IDX_W.
module tourney_pred
    import tp_pkg::*;
#(
    parameter int GH_W      = 8,
    parameter int LHT_IDX_W = 6,
    parameter int LH_W      = 6,
    parameter int CHS_IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CHS_IDX_W-1:0] req_idx,
    output logic                 pred_taken,
    output logic                 pred_gbl,
    output logic                 pred_lcl,
    input  logic                 upd_valid,
    input  logic [CHS_IDX_W-1:0] upd_idx,
    input  logic                 upd_taken,
    input  logic                 upd_gbl_pred,
    input  logic                 upd_lcl_pred
);
    logic [GH_W-1:0] ghist;
    logic [LH_W-1:0] lhist_rd;
    logic [LH_W-1:0] lhist_wr;
    logic            chs_hi;
    pick_e           pick;
    logic            gbl_ok;
    logic            lcl_ok;
    logic            chs_wr_en;

    // Histories: global register and local table.
    tp_hist_unit #(
        .GH_W      (GH_W),
        .LHT_IDX_W (LHT_IDX_W),
        .LH_W      (LH_W)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (req_idx[LHT_IDX_W-1:0]),
        .lhist_rd  (lhist_rd),
        .ghist     (ghist),
        .upd_valid (upd_valid),
        .wr_idx    (upd_idx[LHT_IDX_W-1:0]),
        .upd_taken (upd_taken),
        .lhist_wr  (lhist_wr)
    );

    // Global component: counters indexed by committed global history.
    tp_sat_table #(
        .IDX_W   (GH_W),
        .CW      (GCTR_W),
        .RST_VAL (GCTR_RST)
    ) u_gbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghist),
        .rd_hi  (pred_gbl),
        .wr_en  (upd_valid),
        .wr_idx (ghist),
        .wr_up  (upd_taken)
    );

    // Local component: counters indexed by the branch's own history.
    tp_sat_table #(
        .IDX_W   (LH_W),
        .CW      (LCTR_W),
        .RST_VAL (LCTR_RST)
    ) u_lcl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lhist_rd),
        .rd_hi  (pred_lcl),
        .wr_en  (upd_valid),
        .wr_idx (lhist_wr),
        .wr_up  (upd_taken)
    );

    // Chooser moves only when exactly one component was right; up means local.
    assign gbl_ok    = (upd_gbl_pred == upd_taken);
    assign lcl_ok    = (upd_lcl_pred == upd_taken);
    assign chs_wr_en = upd_valid && (gbl_ok != lcl_ok);

    tp_sat_table #(
        .IDX_W   (CHS_IDX_W),
        .CW      (CHS_W),
        .RST_VAL (CHS_RST)
    ) u_chs (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_idx),
        .rd_hi  (chs_hi),
        .wr_en  (chs_wr_en),
        .wr_idx (upd_idx),
        .wr_up  (lcl_ok)
    );

    // Final pick from the chooser's upper half.
    always_comb begin
        pick       = chs_hi ? PICK_LOCAL : PICK_GLOBAL;
        pred_taken = (pick == PICK_LOCAL) ? pred_lcl : pred_gbl;
    end

    // R5
    agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_gbl == pred_lcl) |-> (pred_taken == pred_gbl))
        else $error("final prediction differs from agreeing components");
endmodule

// File: tb/test_tourney_pred.sv
// Scoreboard bench: the driver computes expected outputs with a reference
// model and queues them; the monitor pops and compares after the inputs settle.
module test_tourney_pred;
    localparam int GH_W = 8, LHT_IDX_W = 6, LH_W = 6, CHS_IDX_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] req_idx = '0;
    logic pred_taken, pred_gbl, pred_lcl;
    logic upd_valid = 1'b0;
    logic [7:0] upd_idx = '0;
    logic upd_taken = 1'b0, upd_gbl_pred = 1'b0, upd_lcl_pred = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tourney_pred #(
        .GH_W(GH_W), .LHT_IDX_W(LHT_IDX_W), .LH_W(LH_W), .CHS_IDX_W(CHS_IDX_W)
    ) i_tourney_pred (
        .clk(clk), .rst_n(rst_n), .req_idx(req_idx),
        .pred_taken(pred_taken), .pred_gbl(pred_gbl), .pred_lcl(pred_lcl),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken),
        .upd_gbl_pred(upd_gbl_pred), .upd_lcl_pred(upd_lcl_pred)
    );

    // Reference model state
    int m_gctr [256];
    int m_lctr [64];
    int m_lht  [64];
    int m_chs  [256];
    int m_gh;

    typedef struct { logic p; logic g; logic l; string tag; } exp_t;
    exp_t exp_q [$];
    event sample_ev;

    function automatic void m_reset();
        for (int i = 0; i < 256; i++) begin m_gctr[i] = 1; m_chs[i] = 1; end
        for (int i = 0; i < 64; i++)  begin m_lctr[i] = 3; m_lht[i] = 0; end
        m_gh = 0;
    endfunction

    function automatic void m_pred(input int a, output logic g, output logic l, output logic p);
        g = (m_gctr[m_gh] >= 2);
        l = (m_lctr[m_lht[a % 64]] >= 4);
        p = (m_chs[a] >= 2) ? l : g;
    endfunction

    function automatic int sat(input int v, input logic up, input int mx);
        if (up) return (v < mx) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    function automatic void m_upd(input int a, input logic t, input logic gp, input logic lp);
        int li;
        li = m_lht[a % 64];
        m_gctr[m_gh] = sat(m_gctr[m_gh], t, 3);
        m_lctr[li]   = sat(m_lctr[li], t, 7);
        if ((gp == t) != (lp == t)) m_chs[a] = sat(m_chs[a], (lp == t), 3);
        m_gh = ((m_gh << 1) | int'(t)) & 255;
        m_lht[a % 64] = ((li << 1) | int'(t)) & 63;
    endfunction

    task automatic step(input logic [7:0] rq, input logic uv, input logic [7:0] ua,
                        input logic t, input logic gp, input logic lp, input string tag);
        exp_t e;
        logic g, l, p;
        @(negedge clk);
        req_idx = rq; upd_valid = uv; upd_idx = ua;
        upd_taken = t; upd_gbl_pred = gp; upd_lcl_pred = lp;
        m_pred(int'(rq), g, l, p);
        e.p = p; e.g = g; e.l = l; e.tag = tag;
        exp_q.push_back(e);
        if (uv) m_upd(int'(ua), t, gp, lp);
        #2 -> sample_ev;
    endtask

    // Resolve a branch with the component predictions the model gives it.
    task automatic resolve(input logic [7:0] a, input logic t, input string tag);
        logic g, l, p;
        m_pred(int'(a), g, l, p);
        step(a, 1'b1, a, t, g, l, tag);
    endtask

    // Monitor: compare each queued expectation against the ports.
    initial begin
        exp_t e;
        forever begin
            @(sample_ev);
            e = exp_q.pop_front();
            checks++;
            if (pred_taken !== e.p || pred_gbl !== e.g || pred_lcl !== e.l) begin
                errors++;
                $display("FAIL %s: got taken=%b gbl=%b lcl=%b expected taken=%b gbl=%b lcl=%b",
                         e.tag, pred_taken, pred_gbl, pred_lcl, e.p, e.g, e.l);
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state reads not taken everywhere
        step(8'h00, 0, 8'h00, 0, 0, 0, "R1");
        step(8'hA5, 0, 8'h00, 0, 0, 0, "R1");
        step(8'hFF, 0, 8'h00, 0, 0, 0, "R1");

        // R6: local right, global wrong twice -> chooser moves to local
        step(8'h21, 1, 8'h21, 1, 0, 1, "R6");
        step(8'h21, 1, 8'h21, 1, 0, 1, "R6");
        step(8'h21, 1, 8'h21, 1, 0, 1, "R6 saturate high");
        step(8'h21, 0, 8'h00, 0, 0, 0, "R5 local picked");
        // R7: both right / both wrong leave chooser unchanged
        step(8'h21, 1, 8'h21, 0, 0, 0, "R7 both right");
        step(8'h21, 1, 8'h21, 1, 0, 0, "R7 both wrong");
        step(8'h21, 0, 8'h00, 0, 0, 0, "R7");
        // R6: global right, local wrong moves back toward global
        for (int k = 0; k < 4; k++) step(8'h21, 1, 8'h21, 0, 0, 1, "R6 toward global");
        step(8'h21, 0, 8'h00, 0, 0, 0, "R5 global picked");

        // R9: upd_valid low with busy fields changes nothing
        for (int k = 0; k < 6; k++)
            step(8'h21, 0, 8'(k * 37), 1'(k), 1'(k >> 1), 1'(~k), "R9 ignored");

        // R4: long taken run saturates global and local counters
        for (int k = 0; k < 20; k++) resolve(8'h40, 1, "R4 taken run");
        for (int k = 0; k < 20; k++) resolve(8'h40, 0, "R4 not-taken run");

        // R3: alternating pattern on one branch trains the local table
        for (int k = 0; k < 40; k++) resolve(8'h13, 1'(k & 1), "R3 alternating");
        // R8: both components keep training regardless of the pick
        for (int k = 0; k < 30; k++) begin
            resolve(8'h07, 1'(k % 3 == 0), "R8 period three");
        end

        // R2: correlated pair, second branch taken when first was not
        for (int k = 0; k < 40; k++) begin
            logic t1;
            t1 = 1'(k % 2);
            resolve(8'h50, t1, "R2 first");
            resolve(8'h51, ~t1, "R2 second");
        end

        // R10: indices sharing low six bits share local history, not chooser
        step(8'h05, 1, 8'h05, 1, 0, 1, "R10");
        step(8'h45, 1, 8'h45, 0, 0, 1, "R10");
        step(8'h05, 0, 8'h00, 0, 0, 0, "R10 alias read");
        step(8'h45, 0, 8'h00, 0, 0, 0, "R10 alias read");
        for (int k = 0; k < 12; k++) resolve(8'(8'h05 + ((k & 1) << 6)), 1'(k % 4 != 0), "R10 alias train");

        // Mixed traffic: random branches with biased outcomes
        for (int k = 0; k < 400; k++) begin
            logic [7:0] a;
            logic t;
            a = 8'($urandom_range(0, 15) * 13);
            t = (a[2] ^ 1'(m_gh & 1)) | ($urandom_range(0, 7) == 0);
            resolve(a, t, "R8 mixed");
        end

        // Mid-run reset returns to R1 state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_reset();
        step(8'h21, 0, 8'h00, 0, 0, 0, "R1 after reset");
        step(8'h13, 0, 8'h00, 0, 0, 0, "R1 after reset");

        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule